// File: doc/BRIEF.md
# Hashed Page Table Walker

This block looks up a translation entry in a hashed page table held in memory. A request gives a 24-bit segment identifier and a 32-bit virtual address. The walker forms a hash from the identifier and the page index, and turns it into a group offset. It then scans that group's eight entries through a single memory port. If no entry in the primary group matches, it scans a second group whose offset comes from the bitwise complement of the hash. When it finds an entry and the caller has granted the access, it sets the entry's referenced bit. On a store it also sets the changed bit. Each of these updates is a single-byte write to the table.

The caller asserts `start` for one cycle while the walker is idle. It keeps the table base and mask stable until `done` pulses. The result is the hit/miss flag, both words of the matching entry as they were read, and the entry's byte offset within the table. The result holds until the next request. Permission policy and fault encoding are the caller's job: the `upd_grant` input only says whether the status bits may be updated.

Top module: `hpt_walker`

## Requirements
- R1: The page index is vaddr[27:12]. The primary hash is the segment identifier XOR the page index, both zero-extended to 32 bits. The first read of a walk goes to tbl_base + ((hash << 6) & tbl_mask).
- R2: An entry's first word matches only under three conditions: bit 31 (valid) is 1, bit 6 equals the current probe (0 primary, 1 secondary), and bits 30:7 equal the segment identifier while bits 5:0 equal page index bits 15:10.
- R3: Entries are 8 bytes apart and are scanned from index 0 upward. The first match ends the walk, and pte_off reports the group offset plus 8 times the index.
- R4: The first word of each entry (at the entry address) is read before its second word (at entry address + 4). The second word is read only for a matching entry.
- R5: After eight primary entries fail to match, the walker scans the group at offset ((~hash) << 6) & tbl_mask. There, bit 6 must be 1 for a match.
- R6: If neither group matches, done pulses with hit low after exactly 16 reads, and no write is issued.
- R7: On a hit with upd_grant high and second-word bit 8 (referenced) clear, one write goes to entry address + 4. It has mem_be = 4'b0010 (byte offset 6 = data bits 15:8), and those data bits are the old byte with bit 0 set.
- R8: On a hit with upd_grant high, is_store high and second-word bit 7 (changed) clear, one write goes to entry address + 4. It has mem_be = 4'b0001 (byte offset 7 = data bits 7:0), and those data bits are the old byte with bit 7 set. It is issued after the R7 write when both apply. A load never sets the changed bit.
- R9: With upd_grant low, a hit issues no write.
- R10: mem_req stays high with a stable address until mem_ack. done is a one-cycle pulse, after which the walker is idle and its result outputs hold.
- R11: While in reset, mem_req and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request strobe while idle |
| seg_vsid | input | 24 | Segment identifier |
| vaddr | input | 32 | Virtual address |
| is_store | input | 1 | Access is a store |
| upd_grant | input | 1 | Access allowed; status bits may be written |
| tbl_base | input | 32 | Table base address |
| tbl_mask | input | 32 | Table offset mask |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address (word aligned) |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables, bit k covers data bits 8k+7:8k |
| mem_ack | input | 1 | Request completed; read data valid |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | An entry was found |
| pte_hi | output | 32 | First word of the found entry |
| pte_lo | output | 32 | Second word of the found entry, as read |
| pte_off | output | 32 | Byte offset of the found entry in the table |

## Verification
A wrong entry index or probe flag inside the walker shows up on the memory port before the walk ends. The read addresses stop following the expected ascending pattern, and the read count at `done` differs from the model's. A stale copy of the second word is different: it only shows in the written byte lanes, or in `pte_lo` at the `done` pulse of that request. The bench therefore checks the first read address, the read count, every write and all result fields on each `done`.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    // Status bit positions inside the second entry word; the byte lanes
    // that the update writes use depend on them.
    localparam int REF_BIT = 8;
    localparam int CHG_BIT = 7;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RD_HI = 3'd1,
        ST_RD_LO = 3'd2,
        ST_WR_R  = 3'd3,
        ST_WR_C  = 3'd4,
        ST_DONE  = 3'd5
    } walk_st_e;

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
    parameter int ADDR_W    = 32,
    parameter int VSID_W    = 24,
    parameter int PIDX_W    = 16,
    parameter int API_W     = 6,
    parameter int GRP_SHIFT = 6
) (
    input  logic [VSID_W-1:0]       vsid,
    input  logic [PIDX_W-1:0]       pidx,
    input  logic                    secondary,
    input  logic [ADDR_W-1:0]       tbl_mask,
    output logic [ADDR_W-1:0]       grp_off,
    output logic [VSID_W+API_W-1:0] tag
);

    logic [ADDR_W-1:0] h_pri;
    logic [ADDR_W-1:0] h_sel;

    assign h_pri   = ADDR_W'(vsid) ^ ADDR_W'(pidx);
    assign h_sel   = secondary ? ~h_pri : h_pri;
    assign grp_off = (h_sel << GRP_SHIFT) & tbl_mask;
    assign tag     = {vsid, pidx[PIDX_W-1 -: API_W]};

endmodule

// File: rtl/hpt_match.sv
module hpt_match #(
    parameter int WORD_W = 32,
    parameter int VSID_W = 24,
    parameter int API_W  = 6
) (
    input  logic [WORD_W-1:0]       word_hi,
    input  logic                    probe,
    input  logic [VSID_W+API_W-1:0] tag,
    output logic                    match
);

    // Layout: valid at the top, identifier below it, probe flag above the
    // abbreviated page index.
    logic                    valid;
    logic                    hflag;
    logic [VSID_W+API_W-1:0] etag;

    assign valid = word_hi[WORD_W-1];
    assign hflag = word_hi[API_W];
    assign etag  = {word_hi[WORD_W-2 -: VSID_W], word_hi[API_W-1:0]};
    assign match = valid && (hflag == probe) && (etag == tag);

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker #(
    parameter int ADDR_W      = 32,
    parameter int VSID_W      = 24,
    parameter int PAGE_SHIFT  = 12,
    parameter int SEG_SHIFT   = 28,
    parameter int API_W       = 6,
    parameter int ENTRIES     = 8,
    parameter int ENTRY_BYTES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [VSID_W-1:0]   seg_vsid,
    input  logic [ADDR_W-1:0]   vaddr,
    input  logic                is_store,
    input  logic                upd_grant,
    input  logic [ADDR_W-1:0]   tbl_base,
    input  logic [ADDR_W-1:0]   tbl_mask,
    output logic                mem_req,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [ADDR_W-1:0]   mem_wdata,
    output logic [ADDR_W/8-1:0] mem_be,
    input  logic                mem_ack,
    input  logic [ADDR_W-1:0]   mem_rdata,
    output logic                done,
    output logic                hit,
    output logic [ADDR_W-1:0]   pte_hi,
    output logic [ADDR_W-1:0]   pte_lo,
    output logic [ADDR_W-1:0]   pte_off
);
    import hpt_pkg::*;

    localparam int PIDX_W      = SEG_SHIFT - PAGE_SHIFT;
    localparam int GROUP_BYTES = ENTRIES * ENTRY_BYTES;
    localparam int GRP_SHIFT   = $clog2(GROUP_BYTES);
    localparam int IDX_W       = $clog2(ENTRIES);
    localparam int ENT_SHIFT   = $clog2(ENTRY_BYTES);
    localparam int WORD_BYTES  = ADDR_W / 8;
    localparam int BE_W        = ADDR_W / 8;
    localparam int TAG_W       = VSID_W + API_W;

    typedef struct packed {
        walk_st_e            st;
        logic [VSID_W-1:0]   vsid;
        logic [PIDX_W-1:0]   pidx;
        logic                store;
        logic                grant;
        logic                probe;
        logic [IDX_W-1:0]    idx;
        logic [ADDR_W-1:0]   grp;
        logic [ADDR_W-1:0]   w_hi;
        logic [ADDR_W-1:0]   w_lo;
        logic                hit;
    } walk_t;

    walk_t r_d, r_q;

    logic              unused_vaddr_bits;
    assign unused_vaddr_bits = ^{vaddr[ADDR_W-1:SEG_SHIFT], vaddr[PAGE_SHIFT-1:0]};

    // Hash inputs come from the ports while idle, from the latched request otherwise.
    logic [VSID_W-1:0] h_vsid;
    logic [PIDX_W-1:0] h_pidx;
    logic              h_sec;
    logic [ADDR_W-1:0] h_grp;
    logic [TAG_W-1:0]  h_tag;
    logic              e_match;

    assign h_vsid = (r_q.st == ST_IDLE) ? seg_vsid : r_q.vsid;
    assign h_pidx = (r_q.st == ST_IDLE) ? vaddr[SEG_SHIFT-1:PAGE_SHIFT] : r_q.pidx;
    assign h_sec  = (r_q.st != ST_IDLE);

    hpt_hash #(
        .ADDR_W(ADDR_W), .VSID_W(VSID_W), .PIDX_W(PIDX_W),
        .API_W(API_W), .GRP_SHIFT(GRP_SHIFT)
    ) u_hash (
        .vsid(h_vsid), .pidx(h_pidx), .secondary(h_sec),
        .tbl_mask(tbl_mask), .grp_off(h_grp), .tag(h_tag)
    );

    hpt_match #(
        .WORD_W(ADDR_W), .VSID_W(VSID_W), .API_W(API_W)
    ) u_match (
        .word_hi(mem_rdata), .probe(r_q.probe), .tag(h_tag), .match(e_match)
    );

    logic [ADDR_W-1:0] ent_off;
    assign ent_off = r_q.grp + (ADDR_W'(r_q.idx) << ENT_SHIFT);

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.vsid  = seg_vsid;
                    r_d.pidx  = vaddr[SEG_SHIFT-1:PAGE_SHIFT];
                    r_d.store = is_store;
                    r_d.grant = upd_grant;
                    r_d.probe = 1'b0;
                    r_d.idx   = '0;
                    r_d.grp   = h_grp;
                    r_d.hit   = 1'b0;
                    r_d.st    = ST_RD_HI;
                end
            end
            ST_RD_HI: begin
                if (mem_ack) begin
                    r_d.w_hi = mem_rdata;
                    if (e_match) begin
                        r_d.st = ST_RD_LO;
                    end else if (r_q.idx != IDX_W'(ENTRIES - 1)) begin
                        r_d.idx = r_q.idx + IDX_W'(1);
                    end else if (!r_q.probe) begin
                        r_d.probe = 1'b1;
                        r_d.idx   = '0;
                        r_d.grp   = h_grp;
                    end else begin
                        r_d.st = ST_DONE;
                    end
                end
            end
            ST_RD_LO: begin
                if (mem_ack) begin
                    r_d.w_lo = mem_rdata;
                    r_d.hit  = 1'b1;
                    if (r_q.grant && !mem_rdata[REF_BIT])
                        r_d.st = ST_WR_R;
                    else if (r_q.grant && r_q.store && !mem_rdata[CHG_BIT])
                        r_d.st = ST_WR_C;
                    else
                        r_d.st = ST_DONE;
                end
            end
            ST_WR_R: begin
                if (mem_ack)
                    r_d.st = (r_q.store && !r_q.w_lo[CHG_BIT]) ? ST_WR_C : ST_DONE;
            end
            ST_WR_C: begin
                if (mem_ack)
                    r_d.st = ST_DONE;
            end
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign mem_req   = (r_q.st == ST_RD_HI) || (r_q.st == ST_RD_LO) ||
                       (r_q.st == ST_WR_R)  || (r_q.st == ST_WR_C);
    assign mem_we    = (r_q.st == ST_WR_R) || (r_q.st == ST_WR_C);
    assign mem_addr  = tbl_base + ent_off +
                       ((r_q.st == ST_RD_HI) ? '0 : ADDR_W'(WORD_BYTES));
    assign mem_wdata = r_q.w_lo | ((r_q.st == ST_WR_R) ? (ADDR_W'(1) << REF_BIT)
                                                      : (ADDR_W'(1) << CHG_BIT));
    assign mem_be    = (r_q.st == ST_WR_R) ? (BE_W'(1) << (REF_BIT / 8)) :
                       (r_q.st == ST_WR_C) ? (BE_W'(1) << (CHG_BIT / 8)) : '0;
    assign done      = (r_q.st == ST_DONE);
    assign hit       = r_q.hit;
    assign pte_hi    = r_q.w_hi;
    assign pte_lo    = r_q.w_lo;
    assign pte_off   = ent_off;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !mem_req)); // R10
    AST_WR_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($countones(mem_be) == 1 && hit)); // R7
    AST_CHG_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be[CHG_BIT / 8]) |-> r_q.store); // R8
    AST_NO_WR_NOGRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> r_q.grant); // R9
    AST_HIT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hit) |-> (pte_hi[ADDR_W-1] && (pte_hi[API_W] == r_q.probe))); // R2

endmodule

// File: tb/hpt_walker_tb.sv
module hpt_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [23:0] seg_vsid = '0;
    logic [31:0] vaddr = '0;
    logic        is_store = 1'b0;
    logic        upd_grant = 1'b0;
    logic [31:0] tbl_base = 32'h0010_0000;
    logic [31:0] tbl_mask = 32'h0000_FFC0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        done, hit;
    logic [31:0] pte_hi, pte_lo, pte_off;

    always #10 clk = ~clk;

    hpt_walker u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .seg_vsid(seg_vsid),
        .vaddr(vaddr), .is_store(is_store), .upd_grant(upd_grant),
        .tbl_base(tbl_base), .tbl_mask(tbl_mask),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .done(done), .hit(hit),
        .pte_hi(pte_hi), .pte_lo(pte_lo), .pte_off(pte_off)
    );

    int errors = 0;
    int checks = 0;

    logic [31:0] mem [int unsigned];

    function automatic logic [31:0] rd(logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Bench-side table model
    function automatic logic [31:0] grp_of(logic [23:0] v, logic [31:0] va, bit sec);
        logic [31:0] h;
        h = {8'h00, v} ^ {16'h0000, va[27:12]};
        if (sec) h = ~h;
        return (h * 32'd64) & tbl_mask;
    endfunction

    function automatic logic [31:0] mk_hi(bit valid, bit h, logic [23:0] v, logic [5:0] api);
        return {valid, v, h, api};
    endfunction

    typedef struct {
        bit          hit;
        logic [31:0] off, whi, wlo, first;
        int          reads, nwr;
        logic [31:0] wa [2];
        logic [31:0] wd [2];
        logic [3:0]  wb [2];
    } exp_t;

    exp_t sb [$];

    // Observed memory traffic
    int          reads_o = 0;
    logic [31:0] first_o = '0;
    logic [31:0] wa_o [$];
    logic [31:0] wd_o [$];
    logic [3:0]  wb_o [$];

    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (rst_n && mem_req) begin
                mem_ack = 1'b1;
                if (mem_we) begin
                    logic [31:0] old;
                    wa_o.push_back(mem_addr);
                    wd_o.push_back(mem_wdata);
                    wb_o.push_back(mem_be);
                    old = rd(mem_addr);
                    for (int k = 0; k < 4; k++)
                        if (mem_be[k]) old[8*k +: 8] = mem_wdata[8*k +: 8];
                    mem[mem_addr] = old;
                end else begin
                    if (reads_o == 0) first_o = mem_addr;
                    reads_o++;
                    mem_rdata = rd(mem_addr);
                end
            end
        end
    end

    function automatic logic [31:0] lane_mask(logic [3:0] be);
        logic [31:0] m = '0;
        for (int k = 0; k < 4; k++) if (be[k]) m[8*k +: 8] = 8'hFF;
        return m;
    endfunction

    // Monitor: pops expected result at each done pulse
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                exp_t e;
                if (sb.size() == 0) begin
                    chk("R10 unexpected done", 32'd1, 32'd0);
                end else begin
                    e = sb.pop_front();
                    chk("R1 first read address", first_o, e.first);
                    chk("R4/R5/R6 read count", reads_o, e.reads);
                    chk("R3/R6 hit flag", {31'd0, hit}, {31'd0, e.hit});
                    if (e.hit) begin
                        chk("R3 entry offset", pte_off, e.off);
                        chk("R2 first word", pte_hi, e.whi);
                        chk("R4 second word", pte_lo, e.wlo);
                    end
                    chk("R7/R8/R9 write count", wa_o.size(), e.nwr);
                    for (int i = 0; i < e.nwr && i < wa_o.size(); i++) begin
                        chk("R7/R8 write address", wa_o[i], e.wa[i]);
                        chk("R7/R8 byte enables", {28'd0, wb_o[i]}, {28'd0, e.wb[i]});
                        chk("R7/R8 write byte", wd_o[i] & lane_mask(e.wb[i]),
                            e.wd[i] & lane_mask(e.wb[i]));
                    end
                end
            end
        end
    end

    // Driver: computes expected outcome from the table model, then issues
    task automatic walk(logic [23:0] v, logic [31:0] va, bit st, bit gr);
        exp_t e;
        logic [31:0] tag_lo;
        e.hit = 0; e.reads = 0; e.nwr = 0;
        e.off = '0; e.whi = '0; e.wlo = '0;
        e.first = tbl_base + grp_of(v, va, 0);
        for (int p = 0; p < 2 && !e.hit; p++) begin
            for (int i = 0; i < 8 && !e.hit; i++) begin
                logic [31:0] off, w;
                off = grp_of(v, va, p[0]) + 32'(i * 8);
                w = rd(tbl_base + off);
                e.reads++;
                if (w[31] && w[6] == p[0] && w[30:7] == v && w[5:0] == va[27:22]) begin
                    e.hit = 1; e.off = off; e.whi = w;
                    e.wlo = rd(tbl_base + off + 4);
                    e.reads++;
                end
            end
        end
        tag_lo = tbl_base + e.off + 4;
        if (e.hit && gr) begin
            if (!e.wlo[8]) begin
                e.wa[e.nwr] = tag_lo; e.wb[e.nwr] = 4'b0010;
                e.wd[e.nwr] = {16'h0, e.wlo[15:8] | 8'h01, 8'h00}; e.nwr++;
            end
            if (st && !e.wlo[7]) begin
                e.wa[e.nwr] = tag_lo; e.wb[e.nwr] = 4'b0001;
                e.wd[e.nwr] = {24'h0, e.wlo[7:0] | 8'h80}; e.nwr++;
            end
        end
        @(negedge clk);
        reads_o = 0; first_o = '0;
        wa_o.delete(); wd_o.delete(); wb_o.delete();
        sb.push_back(e);
        seg_vsid = v; vaddr = va; is_store = st; upd_grant = gr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic put(logic [23:0] v, logic [31:0] va, bit sec, int idx,
                       logic [31:0] whi, logic [31:0] wlo);
        logic [31:0] a;
        a = tbl_base + grp_of(v, va, sec) + 32'(idx * 8);
        mem[a] = whi;
        mem[a + 4] = wlo;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [23:0] v;
        logic [31:0] va;
        repeat (3) @(negedge clk);
        chk("R11 mem_req in reset", {31'd0, mem_req}, 32'd0);
        chk("R11 done in reset", {31'd0, done}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R3 R7: primary entry 0, granted load, referenced bit clear
        v = 24'h000123; va = 32'h1234_5000;
        put(v, va, 0, 0, mk_hi(1, 0, v, va[27:22]), 32'h0ABC_D002);
        walk(v, va, 0, 1);
        repeat (3) @(negedge clk);
        chk("R10 result holds (hit)", {31'd0, hit}, 32'd1);
        chk("R10 result holds (second word)", pte_lo, 32'h0ABC_D002);
        chk("R10 done stays low", {31'd0, done}, 32'd0);

        // R2 R3 R8: decoys before entry 5, two matches, store with R set
        v = 24'h00ABCD; va = 32'h0F00_3000;
        put(v, va, 0, 0, mk_hi(0, 0, v, va[27:22]), 32'h0);
        put(v, va, 0, 1, mk_hi(1, 1, v, va[27:22]), 32'h0);
        put(v, va, 0, 2, mk_hi(1, 0, v, va[27:22] ^ 6'h01), 32'h0);
        put(v, va, 0, 3, mk_hi(1, 0, v ^ 24'h000400, va[27:22]), 32'h0);
        put(v, va, 0, 5, mk_hi(1, 0, v, va[27:22]), 32'h0000_0100);
        put(v, va, 0, 6, mk_hi(1, 0, v, va[27:22]), 32'h5555_5555);
        walk(v, va, 1, 1);

        // R7 R8: store, both bits clear, referenced first then changed
        v = 24'h000777; va = 32'h3000_7000;
        put(v, va, 0, 2, mk_hi(1, 0, v, va[27:22]), 32'h1234_5600);
        walk(v, va, 1, 1);

        // R5: primary full of H=1 lookalikes, hit in secondary entry 3
        v = 24'h0055AA; va = 32'h7777_7000;
        for (int i = 0; i < 8; i++)
            put(v, va, 0, i, mk_hi(1, 1, v, va[27:22]), 32'h0);
        put(v, va, 1, 3, mk_hi(1, 1, v, va[27:22]), 32'h0000_0180);
        walk(v, va, 0, 1);

        // R6: nothing in either group
        walk(24'h000F0F, 32'hABCD_E000, 1, 1);

        // R9: match with both bits clear, access not granted
        v = 24'h0C0C0C; va = 32'h0000_1000;
        put(v, va, 0, 4, mk_hi(1, 0, v, va[27:22]), 32'h0000_0000);
        walk(v, va, 1, 0);

        // R8: first entry again as a store, referenced now set by hardware
        walk(24'h000123, 32'h1234_5000, 1, 1);
        chk("R7 referenced bit stored", rd(32'h0010_0000 + grp_of(24'h000123, 32'h1234_5000, 0) + 4),
            32'h0ABC_D182);

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule